// File: doc/BRIEF.md
# Hardware Loop Address Stack

This block keeps the start addresses of active zero-overhead loops in a small last-in-first-out store. A loop-start command pushes the address of the first instruction in the loop body. A loop-end command covers both an explicit early exit and the natural end of the loop, and it discards the newest address. With every push and pop the block also updates two flags: a loop-active flag and a shadow flag for the enclosing loop. These let the sequencer tell whether it is inside a loop, and whether that loop is nested in another one.

The store is two entries deep with 16-bit addresses by default, and both numbers are parameters. A single-instruction repeat is handled outside this block and never reaches it. A push into a full store is refused. In the same cycle the block drives a request line for a non-maskable overflow interrupt. A pop from an empty store is ignored and raises nothing. When a push and a pop arrive together, the pop is done first and the push second.

Top module: `hw_loop_stack`

## Requirements
- R1: After reset the store is empty, `loop_flag` and `nest_flag` are 0, `top_addr` is 0 and `ovf_irq` is 0.
- R2: An accepted push stores `do_addr`, and `top_addr` shows it from the clock edge that takes the push.
- R3: An accepted push copies the previous `loop_flag` into `nest_flag` and sets `loop_flag` to 1.
- R4: A pop from a non-empty store discards the newest entry. `top_addr` then shows the entry below it, or 0 once the store is empty.
- R5: A pop from a non-empty store copies `nest_flag` into `loop_flag` and clears `nest_flag`.
- R6: Entries come back in last-in-first-out order across the full depth (2 by default).
- R7: A push while the store is full and no pop is present is dropped: `top_addr`, the contents and both flags stay unchanged. `ovf_irq` is 1 during the same cycle as that push.
- R8: A pop from an empty store changes nothing. The occupancy stays at zero, so a later push is the only entry, and no interrupt is raised.
- R9: A push and a pop in the same cycle act as a pop followed by a push. A full store then accepts the new address without an overflow, `loop_flag` ends at 1 and `nest_flag` keeps its old value.
- R10: `ovf_irq` is 0 in every cycle without a rejected push, and `nest_flag` is never 1 while `loop_flag` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| do_req | input | 1 | Loop-start command (push) |
| do_addr | input | 16 | Loop body start address to push |
| end_req | input | 1 | Loop end, explicit or natural (pop) |
| top_addr | output | 16 | Newest stored address, 0 when empty |
| loop_flag | output | 1 | Loop active flag |
| nest_flag | output | 1 | Shadow flag of the enclosing loop |
| ovf_irq | output | 1 | Overflow interrupt request, high while a push is rejected |

## Verification
The assertions assume that `do_req` and `end_req` are valid on every clock edge and that the surrounding sequencer may assert both at once. They assume no handshake: every command is taken or rejected in the cycle it appears. The stimulus changes inputs only on the falling edge and holds each command for exactly one cycle. It checks the combinational interrupt line before the rising edge and the registered outputs just after it. The sequences deliberately drive the store into full and empty and then keep pushing or popping past those limits. They also combine push and pop at the empty, half and full occupancy levels, so that the order rule is checked at each one.

// File: rtl/loop_stack_pkg.sv
package loop_stack_pkg;

   // Decision of one cycle after the pop-then-push ordering is applied
   typedef struct packed {
      logic pop_ok;
      logic push_ok;
      logic reject;
   } stk_op_t;

endpackage

// File: rtl/loop_stack_store.sv
module loop_stack_store #(
   parameter int ADDR_W = 16,
   parameter int DEPTH  = 2,
   parameter int CNT_W  = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [CNT_W-1:0]  wr_idx,
   input  logic [ADDR_W-1:0] wr_data,
   input  logic              rd_valid,
   input  logic [CNT_W-1:0]  rd_idx,
   output logic [ADDR_W-1:0] rd_data
);

   logic [ADDR_W-1:0] slot_q [DEPTH];

   for (genvar g = 0; g < DEPTH; g++) begin : g_slot
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            slot_q[g] <= '0;
         end else if (wr_en && (wr_idx == CNT_W'(g))) begin
            slot_q[g] <= wr_data;
         end
      end
   end

   always_comb begin
      rd_data = '0;
      for (int i = 0; i < DEPTH; i++) begin
         if (rd_valid && (rd_idx == CNT_W'(i))) begin
            rd_data = slot_q[i];
         end
      end
   end

   // R2
   wr_idx_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |-> (wr_idx < CNT_W'(DEPTH)));

endmodule

// File: rtl/loop_stack_ctrl.sv
module loop_stack_ctrl
   import loop_stack_pkg::*;
#(
   parameter int DEPTH = 2,
   parameter int CNT_W = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             push_req,
   input  logic             pop_req,
   output stk_op_t          op,
   output logic [CNT_W-1:0] wr_idx,
   output logic             rd_valid,
   output logic [CNT_W-1:0] rd_idx
);

   localparam logic [CNT_W-1:0] FULL = CNT_W'(DEPTH);

   logic [CNT_W-1:0] cnt_q, cnt_mid, cnt_d;

   always_comb begin
      op.pop_ok  = pop_req && (cnt_q != '0);
      cnt_mid    = op.pop_ok ? cnt_q - 1'b1 : cnt_q;
      op.push_ok = push_req && (cnt_mid != FULL);
      op.reject  = push_req && !op.push_ok;
      cnt_d      = op.push_ok ? cnt_mid + 1'b1 : cnt_mid;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cnt_q <= '0;
      else        cnt_q <= cnt_d;
   end

   assign wr_idx   = cnt_mid;
   assign rd_valid = (cnt_q != '0);
   assign rd_idx   = cnt_q - 1'b1;

   // R6
   cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= FULL);

   // R7
   reject_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
      op.reject |=> (cnt_q == FULL));

   // R8
   empty_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pop_req && !push_req && cnt_q == '0) |=> (cnt_q == '0));

   // R9
   swap_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pop_req && push_req && cnt_q != '0) |=> $stable(cnt_q));

endmodule

// File: rtl/loop_flag_unit.sv
module loop_flag_unit (
   input  logic clk,
   input  logic rst_n,
   input  logic pop_ok,
   input  logic push_ok,
   output logic lf_q,
   output logic nl_q
);

   logic lf_mid, nl_mid, lf_d, nl_d;

   always_comb begin
      lf_mid = pop_ok ? nl_q : lf_q;
      nl_mid = pop_ok ? 1'b0 : nl_q;
      lf_d   = push_ok ? 1'b1   : lf_mid;
      nl_d   = push_ok ? lf_mid : nl_mid;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lf_q <= 1'b0;
         nl_q <= 1'b0;
      end else begin
         lf_q <= lf_d;
         nl_q <= nl_d;
      end
   end

   // R3
   push_sets_lf_chk: assert property (@(posedge clk) disable iff (!rst_n)
      push_ok |=> lf_q);

   // R5
   pop_clears_nl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pop_ok && !push_ok) |=> !nl_q);

   // R10
   nest_implies_loop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      nl_q |-> lf_q);

endmodule

// File: rtl/hw_loop_stack.sv
module hw_loop_stack
   import loop_stack_pkg::*;
#(
   parameter int ADDR_W = 16,
   parameter int DEPTH  = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              do_req,
   input  logic [ADDR_W-1:0] do_addr,
   input  logic              end_req,
   output logic [ADDR_W-1:0] top_addr,
   output logic              loop_flag,
   output logic              nest_flag,
   output logic              ovf_irq
);

   localparam int CNT_W = $clog2(DEPTH + 1);

   initial begin
      assert (DEPTH >= 1) else $error("DEPTH must be at least 1");
      assert (ADDR_W >= 1) else $error("ADDR_W must be at least 1");
   end

   stk_op_t          op;
   logic [CNT_W-1:0] wr_idx, rd_idx;
   logic             rd_valid;

   loop_stack_ctrl #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_ctrl (
      .clk      (clk),
      .rst_n    (rst_n),
      .push_req (do_req),
      .pop_req  (end_req),
      .op       (op),
      .wr_idx   (wr_idx),
      .rd_valid (rd_valid),
      .rd_idx   (rd_idx)
   );

   loop_stack_store #(.ADDR_W(ADDR_W), .DEPTH(DEPTH), .CNT_W(CNT_W)) u_store (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (op.push_ok),
      .wr_idx   (wr_idx),
      .wr_data  (do_addr),
      .rd_valid (rd_valid),
      .rd_idx   (rd_idx),
      .rd_data  (top_addr)
   );

   loop_flag_unit u_flags (
      .clk     (clk),
      .rst_n   (rst_n),
      .pop_ok  (op.pop_ok),
      .push_ok (op.push_ok),
      .lf_q    (loop_flag),
      .nl_q    (nest_flag)
   );

   assign ovf_irq = op.reject;

   // R10
   irq_needs_push_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ovf_irq |-> do_req);

   // R7
   irq_keeps_top_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ovf_irq && !end_req) |=> ($stable(top_addr) && $stable(loop_flag) && $stable(nest_flag)));

   // R2
   push_shows_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (do_req && !ovf_irq) |=> (top_addr == $past(do_addr)));

endmodule

// File: tb/hw_loop_stack_tb.sv
module hw_loop_stack_tb;

   localparam int CLK_PERIOD = 10;
   localparam int NVEC = 16;

   // {push, pop, addr, exp_top, exp_lf, exp_nl, exp_irq}
   localparam logic [36:0] VEC [NVEC] = '{
      {1'b1, 1'b0, 16'h1111, 16'h1111, 1'b1, 1'b0, 1'b0},
      {1'b1, 1'b0, 16'h2222, 16'h2222, 1'b1, 1'b1, 1'b0},
      {1'b1, 1'b0, 16'h3333, 16'h2222, 1'b1, 1'b1, 1'b1},
      {1'b0, 1'b1, 16'h0000, 16'h1111, 1'b1, 1'b0, 1'b0},
      {1'b0, 1'b1, 16'h0000, 16'h0000, 1'b0, 1'b0, 1'b0},
      {1'b0, 1'b1, 16'h0000, 16'h0000, 1'b0, 1'b0, 1'b0},
      {1'b1, 1'b0, 16'hAAAA, 16'hAAAA, 1'b1, 1'b0, 1'b0},
      {1'b1, 1'b1, 16'hBBBB, 16'hBBBB, 1'b1, 1'b0, 1'b0},
      {1'b1, 1'b0, 16'hCCCC, 16'hCCCC, 1'b1, 1'b1, 1'b0},
      {1'b1, 1'b1, 16'hDDDD, 16'hDDDD, 1'b1, 1'b1, 1'b0},
      {1'b0, 1'b1, 16'h0000, 16'hBBBB, 1'b1, 1'b0, 1'b0},
      {1'b0, 1'b0, 16'h5555, 16'hBBBB, 1'b1, 1'b0, 1'b0},
      {1'b0, 1'b1, 16'h0000, 16'h0000, 1'b0, 1'b0, 1'b0},
      {1'b1, 1'b1, 16'h0001, 16'h0001, 1'b1, 1'b0, 1'b0},
      {1'b0, 1'b1, 16'h0000, 16'h0000, 1'b0, 1'b0, 1'b0},
      {1'b1, 1'b0, 16'h7E7E, 16'h7E7E, 1'b1, 1'b0, 1'b0}
   };

   function automatic string vec_tag(int i);
      case (i)
         0:       return "R2/R3";
         1:       return "R3/R6";
         2:       return "R7";
         3, 10:   return "R4/R5/R6";
         4, 12:   return "R4/R5";
         5, 14:   return "R8";
         6:       return "R8/R2";
         7, 9, 13: return "R9";
         11:      return "R10";
         default: return "R2";
      endcase
   endfunction

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        do_req = 1'b0;
   logic [15:0] do_addr = '0;
   logic        end_req = 1'b0;
   logic [15:0] top_addr;
   logic        loop_flag, nest_flag, ovf_irq;

   int n_checks = 0;
   int n_fail   = 0;
   bit done     = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   hw_loop_stack u_dut (
      .clk       (clk),
      .rst_n     (rst_n),
      .do_req    (do_req),
      .do_addr   (do_addr),
      .end_req   (end_req),
      .top_addr  (top_addr),
      .loop_flag (loop_flag),
      .nest_flag (nest_flag),
      .ovf_irq   (ovf_irq)
   );

   task automatic check(string tag, string what, logic [15:0] act, logic [15:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
      end
   endtask

   task automatic check_state(string tag, logic [15:0] t, logic lf, logic nl);
      check(tag, "top_addr", top_addr, t);
      check(tag, "loop_flag", {15'd0, loop_flag}, {15'd0, lf});
      check(tag, "nest_flag", {15'd0, nest_flag}, {15'd0, nl});
   endtask

   // drive at falling edge, check irq mid-cycle, check registers after rising edge
   task automatic step(string tag, logic p, logic q, logic [15:0] a, logic exp_irq);
      @(negedge clk);
      do_req  = p;
      end_req = q;
      do_addr = a;
      #1;
      check(tag, "ovf_irq", {15'd0, ovf_irq}, {15'd0, exp_irq});
      @(posedge clk);
      #1;
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
         $finish;
      end
   endtask

   initial begin
      #(CLK_PERIOD * 5000);
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      repeat (3) @(posedge clk);
      #1;
      // R1 reset state
      check_state("R1", 16'h0000, 1'b0, 1'b0);
      check("R1", "ovf_irq", {15'd0, ovf_irq}, 16'h0000);
      @(negedge clk);
      rst_n = 1'b1;

      for (int i = 0; i < NVEC; i++) begin
         step(vec_tag(i), VEC[i][36], VEC[i][35], VEC[i][34:19], VEC[i][0]);
         check_state(vec_tag(i), VEC[i][18:3], VEC[i][2], VEC[i][1]);
      end

      // R7: repeated rejected pushes, each raises the request
      step("R6", 1'b1, 1'b0, 16'h8888, 1'b0);
      step("R7", 1'b1, 1'b0, 16'h9999, 1'b1);
      check_state("R7", 16'h8888, 1'b1, 1'b1);
      step("R7", 1'b1, 1'b0, 16'h4444, 1'b1);
      check_state("R7", 16'h8888, 1'b1, 1'b1);
      // R10: idle while full, no request
      step("R10", 1'b0, 1'b0, 16'h0000, 1'b0);
      check_state("R10", 16'h8888, 1'b1, 1'b1);
      // R6: unwind in reverse order
      step("R6", 1'b0, 1'b1, 16'h0000, 1'b0);
      check_state("R6", 16'h7E7E, 1'b1, 1'b0);
      step("R6", 1'b0, 1'b1, 16'h0000, 1'b0);
      check_state("R6", 16'h0000, 1'b0, 1'b0);

      // R1: reset while full
      step("R2", 1'b1, 1'b0, 16'h1234, 1'b0);
      step("R2", 1'b1, 1'b0, 16'h5678, 1'b0);
      @(negedge clk);
      do_req = 1'b0;
      rst_n  = 1'b0;
      #1;
      check_state("R1", 16'h0000, 1'b0, 1'b0);
      @(negedge clk);
      rst_n = 1'b1;
      // R8 after reset: store really empty
      step("R8", 1'b0, 1'b1, 16'h0000, 1'b0);
      check_state("R8", 16'h0000, 1'b0, 1'b0);

      finish_run();
   end

endmodule